// File: doc/BRIEF.md
# Keyboard Scan Code Tracker

This block accepts a stream of bytes from a keyboard that uses the first-generation scan code set, one byte for each cycle in which a valid strobe is high. From each byte it maintains a pressed-key bitmap, a left/right shift vector, a ctrl flag and three toggling lock flags. Press codes of printable keys are turned into ASCII characters, with shift and caps lock applied, and the characters are written into a small circular character queue.

A consumer, for example a game loop or a console, takes characters from the queue through a valid/ready port. The lock, shift and ctrl state and the key bitmap are plain outputs, so a host can read them at any time. If the queue is full when a new character arrives, that character is dropped and a sticky overflow flag is raised.

Top module: `scan_key_tracker`

## Requirements
- R1: A byte with bit 7 clear is a press and sets bit `codeByte[6:0]` of `keyMap`. A byte with bit 7 set is a release and clears that same bit. Both changes are visible in the cycle after the byte is accepted.
- R2: `shiftHeld[0]` follows the left shift key (code 0x2A) and `shiftHeld[1]` follows the right shift key (code 0x36). Each bit is set by its own key's press and cleared only by its own key's release.
- R3: `ctrlHeld` is 1 from a press of code 0x1D until a release of that code.
- R4: A press of 0x3A flips `capsLock`, a press of 0x45 flips `numLock` and a press of 0x46 flips `scrollLock`. The release of any of these keys leaves all three flags unchanged.
- R5: The letter codes (0x10-0x19 map to qwertyuiop, 0x1E-0x26 to asdfghjkl, 0x2C-0x32 to zxcvbnm) enqueue the uppercase letter when exactly one of "either shift bit set" and `capsLock` is true. Otherwise they enqueue the lowercase letter.
- R6: The digit codes 0x02-0x0B map to 1234567890 and, with either shift held, to !@#$%^&*(). Caps lock has no effect on them. Code 0x39 maps to 0x20 and code 0x1C maps to 0x0A.
- R7: Releases, the six modifier and lock codes, and every other code produce no queue entry.
- R8: The queue holds 16 characters and delivers them in arrival order. `charValid` is high while the queue is non-empty, and a character is removed on each cycle in which both `charValid` and `charReady` are high.
- R9: A character that arrives while the queue is full and no pop happens in that cycle is dropped. `queueOverflow` then rises and stays high until reset.
- R10: A repeated press of a code whose bit is already set in `keyMap` enqueues its character again.
- R11: When a push and a pop happen in the same cycle on a full queue, the push is accepted, the count stays at 16 and no overflow is flagged.
- R12: After reset every flag, the key bitmap and the shift vector are zero, and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| codeValid | input | 1 | A scan code byte is present this cycle |
| codeByte | input | 8 | Scan code byte |
| charReady | input | 1 | Consumer takes the head character |
| charValid | output | 1 | Queue is non-empty |
| charData | output | 8 | Head character of the queue |
| capsLock | output | 1 | Caps lock state |
| numLock | output | 1 | Num lock state |
| scrollLock | output | 1 | Scroll lock state |
| shiftHeld | output | 2 | Bit 0 is left shift held, bit 1 is right shift held |
| ctrlHeld | output | 1 | Ctrl held |
| keyMap | output | 128 | Pressed state for each 7-bit code |
| queueOverflow | output | 1 | Sticky flag: a character was dropped |

## Verification
Two functions can fall in the same cycle: a character push caused by an incoming press, and a pop by the consumer. This matters most when the queue is full. The bench fills the queue with sixteen repeated presses of one key. It then presents a press of a different letter in the same cycle that `charReady` is high. It then checks three things: the overflow flag stays low, the first character read is the old head, and draining the queue returns fifteen of the old characters followed by the new one. A sweep over every 7-bit code under four shift/caps combinations checks the translation against a table the bench builds from key-row strings.

// File: rtl/scan_kbd_pkg.sv
package scan_kbd_pkg;

  localparam logic [6:0] CODE_LSHIFT = 7'h2A;
  localparam logic [6:0] CODE_RSHIFT = 7'h36;
  localparam logic [6:0] CODE_CTRL   = 7'h1D;
  localparam logic [6:0] CODE_CAPS   = 7'h3A;
  localparam logic [6:0] CODE_NUM    = 7'h45;
  localparam logic [6:0] CODE_SCROLL = 7'h46;

  // strobes from control to datapath
  typedef struct packed {
    logic       keySet;
    logic       keyClr;
    logic [6:0] keyIdx;
    logic       shiftLSet;
    logic       shiftLClr;
    logic       shiftRSet;
    logic       shiftRClr;
    logic       ctrlSet;
    logic       ctrlClr;
    logic       capsFlip;
    logic       numFlip;
    logic       scrollFlip;
    logic       push;
    logic [7:0] pushChar;
  } ctrlStrobe_t;

  // unshifted character for a code, 0 when the code is not printable
  function automatic logic [7:0] baseChar(input logic [6:0] code);
    logic [7:0] ch;
    case (code)
      7'h02: ch = 8'h31; 7'h03: ch = 8'h32; 7'h04: ch = 8'h33; 7'h05: ch = 8'h34;
      7'h06: ch = 8'h35; 7'h07: ch = 8'h36; 7'h08: ch = 8'h37; 7'h09: ch = 8'h38;
      7'h0A: ch = 8'h39; 7'h0B: ch = 8'h30;
      7'h10: ch = 8'h71; 7'h11: ch = 8'h77; 7'h12: ch = 8'h65; 7'h13: ch = 8'h72;
      7'h14: ch = 8'h74; 7'h15: ch = 8'h79; 7'h16: ch = 8'h75; 7'h17: ch = 8'h69;
      7'h18: ch = 8'h6F; 7'h19: ch = 8'h70;
      7'h1E: ch = 8'h61; 7'h1F: ch = 8'h73; 7'h20: ch = 8'h64; 7'h21: ch = 8'h66;
      7'h22: ch = 8'h67; 7'h23: ch = 8'h68; 7'h24: ch = 8'h6A; 7'h25: ch = 8'h6B;
      7'h26: ch = 8'h6C;
      7'h2C: ch = 8'h7A; 7'h2D: ch = 8'h78; 7'h2E: ch = 8'h63; 7'h2F: ch = 8'h76;
      7'h30: ch = 8'h62; 7'h31: ch = 8'h6E; 7'h32: ch = 8'h6D;
      7'h39: ch = 8'h20;
      7'h1C: ch = 8'h0A;
      default: ch = 8'h00;
    endcase
    return ch;
  endfunction

  // symbol produced by a digit-row code with shift held
  function automatic logic [7:0] shiftedDigit(input logic [6:0] code);
    logic [7:0] ch;
    case (code)
      7'h02: ch = 8'h21; 7'h03: ch = 8'h40; 7'h04: ch = 8'h23; 7'h05: ch = 8'h24;
      7'h06: ch = 8'h25; 7'h07: ch = 8'h5E; 7'h08: ch = 8'h26; 7'h09: ch = 8'h2A;
      7'h0A: ch = 8'h28; 7'h0B: ch = 8'h29;
      default: ch = 8'h00;
    endcase
    return ch;
  endfunction

endpackage

// File: rtl/scan_key_ctrl.sv
module scan_key_ctrl
  import scan_kbd_pkg::*;
(
  input  logic        codeValid,
  input  logic [7:0]  codeByte,
  input  logic [1:0]  shiftHeld,
  input  logic        capsLock,
  output ctrlStrobe_t strb
);

  logic [6:0] code;
  logic [7:0] lowerCh;
  logic       isLetter;
  logic       isDigit;
  logic       anyShift;
  logic [7:0] outCh;

  assign code     = codeByte[6:0];
  assign lowerCh  = baseChar(code);
  assign isLetter = (lowerCh >= 8'h61) && (lowerCh <= 8'h7A);
  assign isDigit  = (code >= 7'h02) && (code <= 7'h0B);
  assign anyShift = |shiftHeld;

  always_comb begin
    if (isLetter)
      outCh = (anyShift ^ capsLock) ? (lowerCh - 8'h20) : lowerCh;
    else if (isDigit && anyShift)
      outCh = shiftedDigit(code);
    else
      outCh = lowerCh;
  end

  always_comb begin
    strb        = '0;
    strb.keyIdx = code;
    if (codeValid) begin
      if (codeByte[7]) begin
        strb.keyClr = 1'b1;
        case (code)
          CODE_LSHIFT: strb.shiftLClr = 1'b1;
          CODE_RSHIFT: strb.shiftRClr = 1'b1;
          CODE_CTRL:   strb.ctrlClr   = 1'b1;
          default:     ;
        endcase
      end else begin
        strb.keySet = 1'b1;
        case (code)
          CODE_LSHIFT: strb.shiftLSet  = 1'b1;
          CODE_RSHIFT: strb.shiftRSet  = 1'b1;
          CODE_CTRL:   strb.ctrlSet    = 1'b1;
          CODE_CAPS:   strb.capsFlip   = 1'b1;
          CODE_NUM:    strb.numFlip    = 1'b1;
          CODE_SCROLL: strb.scrollFlip = 1'b1;
          default: begin
            strb.push     = (outCh != 8'h00);
            strb.pushChar = outCh;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/scan_key_dpath.sv
module scan_key_dpath
  import scan_kbd_pkg::*;
#(
  parameter int KEY_COUNT = 128,
  parameter int DEPTH     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strb,
  input  logic                 charReady,
  output logic                 charValid,
  output logic [7:0]           charData,
  output logic                 capsLock,
  output logic                 numLock,
  output logic                 scrollLock,
  output logic [1:0]           shiftHeld,
  output logic                 ctrlHeld,
  output logic [KEY_COUNT-1:0] keyMap,
  output logic                 queueOverflow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // per-key pressed bits
  for (genvar k = 0; k < KEY_COUNT; k++) begin : g_key
    always_ff @(posedge clk) begin
      if (!rstN)
        keyMap[k] <= 1'b0;
      else if (strb.keySet && (strb.keyIdx == 7'(k)))
        keyMap[k] <= 1'b1;
      else if (strb.keyClr && (strb.keyIdx == 7'(k)))
        keyMap[k] <= 1'b0;
    end
  end

  // modifier and lock state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftHeld  <= 2'b00;
      ctrlHeld   <= 1'b0;
      capsLock   <= 1'b0;
      numLock    <= 1'b0;
      scrollLock <= 1'b0;
    end else begin
      if (strb.shiftLSet)      shiftHeld[0] <= 1'b1;
      else if (strb.shiftLClr) shiftHeld[0] <= 1'b0;
      if (strb.shiftRSet)      shiftHeld[1] <= 1'b1;
      else if (strb.shiftRClr) shiftHeld[1] <= 1'b0;
      if (strb.ctrlSet)        ctrlHeld <= 1'b1;
      else if (strb.ctrlClr)   ctrlHeld <= 1'b0;
      if (strb.capsFlip)       capsLock   <= ~capsLock;
      if (strb.numFlip)        numLock    <= ~numLock;
      if (strb.scrollFlip)     scrollLock <= ~scrollLock;
    end
  end

  // circular character queue
  logic [7:0]       qMem [DEPTH];
  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic [CNT_W-1:0] qCount;
  logic             popFire;
  logic             pushFire;
  logic             pushDrop;

  assign popFire  = charReady && (qCount != '0);
  assign pushFire = strb.push && ((qCount != FULL_CNT) || popFire);
  assign pushDrop = strb.push && !pushFire;

  always_ff @(posedge clk) begin
    if (pushFire) qMem[tailPtr] <= strb.pushChar;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr       <= '0;
      tailPtr       <= '0;
      qCount        <= '0;
      queueOverflow <= 1'b0;
    end else begin
      if (pushFire) tailPtr <= (tailPtr == LAST_PTR) ? '0 : tailPtr + PTR_W'(1);
      if (popFire)  headPtr <= (headPtr == LAST_PTR) ? '0 : headPtr + PTR_W'(1);
      case ({pushFire, popFire})
        2'b10:   qCount <= qCount + CNT_W'(1);
        2'b01:   qCount <= qCount - CNT_W'(1);
        default: ;
      endcase
      if (pushDrop) queueOverflow <= 1'b1;
    end
  end

  assign charValid = (qCount != '0);
  assign charData  = qMem[headPtr];

  // R8: occupancy never exceeds the queue depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= FULL_CNT);

  // R9: overflow flag is sticky
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    queueOverflow |=> queueOverflow);

  // R11: push and pop together on a full queue keep it full
  a_r11_full_both: assert property (@(posedge clk) disable iff (!rstN)
    (qCount == FULL_CNT && strb.push && charReady) |=> (qCount == FULL_CNT));

  // R8: a waiting head character holds until taken
  a_r8_head_hold: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && !charReady) |=> (charValid && $stable(charData)));

endmodule

// File: rtl/scan_key_tracker.sv
module scan_key_tracker
  import scan_kbd_pkg::*;
#(
  parameter int KEY_COUNT = 128,
  parameter int DEPTH     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 codeValid,
  input  logic [7:0]           codeByte,
  input  logic                 charReady,
  output logic                 charValid,
  output logic [7:0]           charData,
  output logic                 capsLock,
  output logic                 numLock,
  output logic                 scrollLock,
  output logic [1:0]           shiftHeld,
  output logic                 ctrlHeld,
  output logic [KEY_COUNT-1:0] keyMap,
  output logic                 queueOverflow
);

  ctrlStrobe_t strb;

  scan_key_ctrl ctrl_i (
    .codeValid (codeValid),
    .codeByte  (codeByte),
    .shiftHeld (shiftHeld),
    .capsLock  (capsLock),
    .strb      (strb)
  );

  scan_key_dpath #(
    .KEY_COUNT (KEY_COUNT),
    .DEPTH     (DEPTH)
  ) dpath_i (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .charReady     (charReady),
    .charValid     (charValid),
    .charData      (charData),
    .capsLock      (capsLock),
    .numLock       (numLock),
    .scrollLock    (scrollLock),
    .shiftHeld     (shiftHeld),
    .ctrlHeld      (ctrlHeld),
    .keyMap        (keyMap),
    .queueOverflow (queueOverflow)
  );

  // R4: a release never changes a lock flag
  a_r4_lock_release: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && codeByte[7]) |=>
      (capsLock == $past(capsLock) && numLock == $past(numLock) &&
       scrollLock == $past(scrollLock)));

  // R1: a released key reads as not pressed afterwards
  a_r1_release_clears: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && codeByte[7]) |=> !keyMap[$past(codeByte[6:0])]);

  // R1: a pressed key reads as pressed afterwards
  a_r1_press_sets: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && !codeByte[7]) |=> keyMap[$past(codeByte[6:0])]);

endmodule

// File: tb/scan_key_tracker_tb.sv
module scan_key_tracker_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         codeValid = 1'b0;
  logic [7:0]   codeByte = 8'h00;
  logic         charReady = 1'b0;
  logic         charValid;
  logic [7:0]   charData;
  logic         capsLock, numLock, scrollLock, ctrlHeld, queueOverflow;
  logic [1:0]   shiftHeld;
  logic [127:0] keyMap;

  int testsRun = 0;
  int testsFail = 0;

  always #2 clk = ~clk;

  scan_key_tracker dut_i (
    .clk(clk), .rstN(rstN), .codeValid(codeValid), .codeByte(codeByte),
    .charReady(charReady), .charValid(charValid), .charData(charData),
    .capsLock(capsLock), .numLock(numLock), .scrollLock(scrollLock),
    .shiftHeld(shiftHeld), .ctrlHeld(ctrlHeld), .keyMap(keyMap),
    .queueOverflow(queueOverflow)
  );

  task automatic check(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic sendCode(input logic [7:0] b);
    codeValid = 1'b1;
    codeByte  = b;
    @(negedge clk);
    codeValid = 1'b0;
  endtask

  task automatic popOne();
    charReady = 1'b1;
    @(negedge clk);
    charReady = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic bit isModCode(input int c);
    return (c == 'h2A || c == 'h36 || c == 'h1D || c == 'h3A || c == 'h45 || c == 'h46);
  endfunction

  // expected character built from key-row strings
  function automatic int expChar(input int code, input bit sh, input bit cp);
    string r1 = "qwertyuiop";
    string r2 = "asdfghjkl";
    string r3 = "zxcvbnm";
    string dg = "1234567890";
    string ds = "!@#$%^&*()";
    int c = 0;
    if (code >= 2 && code <= 11) return sh ? int'(ds[code-2]) : int'(dg[code-2]);
    if (code >= 16 && code <= 25) c = int'(r1[code-16]);
    else if (code >= 30 && code <= 38) c = int'(r2[code-30]);
    else if (code >= 44 && code <= 50) c = int'(r3[code-44]);
    if (c != 0) return (sh ^ cp) ? c - 32 : c;
    if (code == 'h39) return 'h20;
    if (code == 'h1C) return 'h0A;
    return 0;
  endfunction

  task automatic sweep(input bit sh, input bit cp);
    for (int code = 0; code < 128; code++) begin
      int e;
      if (isModCode(code)) continue;
      e = expChar(code, sh, cp);
      sendCode(8'(code));
      check("R1 press sets key bit", int'(keyMap[code]), 1);
      check("R7 entry only for printable press", int'(charValid), int'(e != 0));
      if (e != 0) begin
        check("R5/R6 translated character", int'(charData), e);
        popOne();
      end
      sendCode(8'(code) | 8'h80);
      check("R1 release clears key bit", int'(keyMap[code]), 0);
      check("R7 release adds no entry", int'(charValid), 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    testsFail++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    // R12 reset state
    check("R12 charValid after reset", int'(charValid), 0);
    check("R12 locks after reset", int'({capsLock, numLock, scrollLock}), 0);
    check("R12 shift/ctrl after reset", int'({shiftHeld, ctrlHeld}), 0);
    check("R12 keyMap after reset", int'(keyMap != '0), 0);
    check("R12 overflow after reset", int'(queueOverflow), 0);

    // R2 shift bits
    sendCode(8'h2A); check("R2 left shift press", int'(shiftHeld), 1);
    sendCode(8'h36); check("R2 right shift press", int'(shiftHeld), 3);
    sendCode(8'hAA); check("R2 left shift release", int'(shiftHeld), 2);
    sendCode(8'hB6); check("R2 right shift release", int'(shiftHeld), 0);
    check("R7 modifiers add no entry", int'(charValid), 0);

    // R3 ctrl
    sendCode(8'h1D); check("R3 ctrl press", int'(ctrlHeld), 1);
    sendCode(8'h9D); check("R3 ctrl release", int'(ctrlHeld), 0);

    // R4 locks
    sendCode(8'h3A); check("R4 caps press", int'(capsLock), 1);
    sendCode(8'hBA); check("R4 caps release no change", int'(capsLock), 1);
    sendCode(8'h3A); check("R4 caps second press", int'(capsLock), 0);
    sendCode(8'h45); check("R4 num press", int'(numLock), 1);
    sendCode(8'hC5); check("R4 num release no change", int'(numLock), 1);
    sendCode(8'h46); check("R4 scroll press", int'(scrollLock), 1);
    sendCode(8'hC6); check("R4 scroll release no change", int'(scrollLock), 1);
    check("R7 locks add no entry", int'(charValid), 0);
    check("R4 caps untouched by others", int'(capsLock), 0);

    // sweeps over four shift/caps combinations
    sweep(1'b0, 1'b0);
    sendCode(8'h2A); sweep(1'b1, 1'b0); sendCode(8'hAA);
    sendCode(8'h3A); sendCode(8'hBA); sweep(1'b0, 1'b1);
    sendCode(8'h36); sweep(1'b1, 1'b1); sendCode(8'hB6);
    sendCode(8'h3A); sendCode(8'hBA);

    // R8 order
    sendCode(8'h10); sendCode(8'h11); sendCode(8'h12);
    check("R8 first out", int'(charData), 'h71); popOne();
    check("R8 second out", int'(charData), 'h77); popOne();
    check("R8 third out", int'(charData), 'h65); popOne();
    check("R8 empty", int'(charValid), 0);
    sendCode(8'h90); sendCode(8'h91); sendCode(8'h92);

    // R10 auto-repeat and R9 overflow
    for (int i = 0; i < 20; i++) sendCode(8'h1E);
    check("R9 overflow set", int'(queueOverflow), 1);
    for (int i = 0; i < 16; i++) begin
      check("R10 repeated press queued", int'(charData), 'h61);
      check("R8 valid while entries remain", int'(charValid), 1);
      popOne();
    end
    check("R9 dropped extras", int'(charValid), 0);
    check("R9 overflow sticky", int'(queueOverflow), 1);
    sendCode(8'h9E);

    // R11 simultaneous push and pop when full
    doReset();
    check("R12 overflow cleared by reset", int'(queueOverflow), 0);
    for (int i = 0; i < 16; i++) sendCode(8'h30);
    check("R9 full without drop", int'(queueOverflow), 0);
    codeValid = 1'b1; codeByte = 8'h2E; charReady = 1'b1;
    @(negedge clk);
    codeValid = 1'b0; charReady = 1'b0;
    check("R11 no overflow on push with pop", int'(queueOverflow), 0);
    for (int i = 0; i < 15; i++) begin
      check("R11 old entries kept", int'(charData), 'h62);
      popOne();
    end
    check("R11 new entry accepted", int'(charData), 'h63);
    popOne();
    check("R11 queue drained", int'(charValid), 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule